// File: doc/BRIEF.md
# Stack Pointer Unit with Limit Traps

This unit keeps the stack pointer and the stack-limit register of a small 16-bit processor data path. It turns push, pop, call and exception-entry requests into effective addresses for the data memory, and it supplies the write data. The stack grows upward and the pointer always names the next free word. A push stores at the pointer and then adds one word. A pop first steps back one word and then reads. Every access address is checked against the programmable upper limit and against a fixed floor that protects the special-function register region. A violation raises a one-cycle trap, and that trap also suppresses the memory access.

A call or an exception entry pushes a 23-bit program counter as two words on two consecutive cycles. The low sixteen bits go first. The second word carries the upper PC bits. For a call, everything above those bits is zero. For an exception, the low status byte sits on top of them. During the second cycle the unit reports itself busy and ignores new requests.

The address, write strobes and trap are combinational in the request cycle. The pointer updates on the following clock edge. For one cycle after it is written, the limit register keeps serving its previous value to the checker.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held, and just after it is released, sp_o reads 0x0800, busy_o is 0, and mem_we_o, mem_re_o and trap_o are 0.
- R2: A push that passes the checks drives mem_addr_o equal to sp_o, asserts mem_we_o, drives mem_wdata_o equal to push_data_i, and raises sp_o by 2 at the next edge.
- R3: A pop that passes the checks drives mem_addr_o equal to sp_o minus 2 and asserts mem_re_o. At the next edge sp_o takes that address.
- R4: Bit 0 of the pointer and of the limit is stored as 0 whatever value is written. Writing 0x0A03 gives a pointer of 0x0A02, and a limit of 0x0A02 when written to the limit.
- R5: An access whose address is greater than the limit traps. An access at an address equal to the limit does not trap. With a limit of L, the push at L succeeds and the push at L+2 traps.
- R6: An access whose address is below 0x0800 traps. This covers a pop taken at a pointer of 0x0800 and a push taken from a pointer written below 0x0800.
- R7: The trap is asserted only in the cycle of the offending access. In that cycle mem_we_o and mem_re_o stay 0, and sp_o is unchanged at the next edge.
- R8: A call writes pc_i[15:0] at sp_o in its first cycle. In the next cycle, with busy_o at 1, it writes {9'b0, pc[22:16]} at sp_o+2, using the PC captured in the first cycle. The pointer then ends 4 higher.
- R9: An exception entry follows the same two-cycle sequence. Its second word is {sr_i[7:0], 1'b0, pc[22:16]}, with sr_i captured in the first cycle.
- R10: Each word of a frame is checked on its own. If the first word traps, nothing is written, busy_o stays 0 and the pointer does not move. If only the second word traps, the first word stays written and the pointer ends 2 higher.
- R11: An access in the cycle right after a limit write is checked against the previous limit. From the second cycle after the write on, the new limit applies.
- R12: A pointer write in a cycle overrides all stack requests, and no access takes place. Among requests the priority is exception, then call, then push, then pop. Requests made while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push one data word |
| pop_i | input | 1 | Pop one word |
| call_i | input | 1 | Push a call frame (two words) |
| exc_i | input | 1 | Push an exception frame (two words) |
| push_data_i | input | 16 | Data word for a push |
| sp_we_i | input | 1 | Load the stack pointer |
| sp_wdata_i | input | 16 | New stack pointer value |
| lim_we_i | input | 1 | Load the limit register |
| lim_wdata_i | input | 16 | New limit value |
| pc_i | input | 23 | Program counter to save |
| sr_i | input | 8 | Low status byte saved on exception |
| mem_addr_o | output | 16 | Effective byte address of the access |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 16 | Memory write data |
| trap_o | output | 1 | Stack-error trap pulse |
| busy_o | output | 1 | Second word of a frame in progress |
| sp_o | output | 16 | Current stack pointer |

## Verification
The pointer is a register and its value can be read at any time. A wrong step, a lost alignment or a move after a trap therefore shows on sp_o one edge after the access, and it also shifts mem_addr_o for the next access. A corrupted limit, or a limit that is not delayed by one cycle, appears as a trap_o pulse that comes one push too early or too late in the limit sweeps. A mis-captured frame word shows on mem_wdata_o during the busy cycle. Both checks are made even though pc_i and sr_i are changed in that same cycle.

// File: rtl/spu_pkg.sv
`timescale 1ns/1ps
package spu_pkg;
  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_POP,
    REQ_PUSH,
    REQ_CALL,
    REQ_EXC
  } spu_req_e;

  typedef enum logic {
    PH_FIRST,
    PH_SECOND
  } spu_phase_e;
endpackage

// File: rtl/spu_limit.sv
`timescale 1ns/1ps
module spu_limit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_we_i,
  input  logic [DW-1:0] lim_wdata_i,
  output logic [DW-1:0] lim_use_o
);
  function automatic logic [DW-1:0] f_align(input logic [DW-1:0] v);
    return {v[DW-1:1], 1'b0};
  endfunction

  // The architectural value holds nothing defined until software writes it.
  logic [DW-1:0] lim_q;
  // The checker reads a copy that trails lim_q by one cycle (write hazard).
  logic [DW-1:0] lim_use_q;

  always_ff @(posedge clk) begin
    if (lim_we_i) lim_q <= f_align(lim_wdata_i);
    lim_use_q <= lim_q;
  end

  assign lim_use_o = lim_use_q;

  // R11: once a cycle passes with no write, the copy in use matches the register.
  p_lim_settled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lim_we_i) |-> (lim_use_q == lim_q));
endmodule

// File: rtl/spu_agu.sv
`timescale 1ns/1ps
module spu_agu #(
  parameter int              DW       = 16,
  parameter logic [DW-1:0]   FLOOR    = 16'h0800,
  parameter logic [DW-1:0]   SP_RESET = 16'h0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_wdata_i,
  input  logic          is_pop_i,
  input  logic          commit_i,
  input  logic [DW-1:0] lim_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] ea_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [DW-1:0] WORD_BYTES = DW'(2);

  function automatic logic [DW-1:0] f_align(input logic [DW-1:0] v);
    return {v[DW-1:1], 1'b0};
  endfunction

  // Pop pre-decrements; push uses the pointer as it is.
  function automatic logic [DW-1:0] f_ea(input logic [DW-1:0] sp, input logic pop);
    return pop ? (sp - WORD_BYTES) : sp;
  endfunction

  // Pointer after a completed access.
  function automatic logic [DW-1:0] f_next(input logic [DW-1:0] sp, input logic pop);
    return pop ? (sp - WORD_BYTES) : (sp + WORD_BYTES);
  endfunction

  logic [DW-1:0] sp_q;
  logic [DW-1:0] ea;

  assign ea    = f_ea(sp_q, is_pop_i);
  assign ovf_o = (ea > lim_i);
  assign unf_o = (ea < FLOOR);
  assign ea_o  = ea;
  assign sp_o  = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sp_q <= SP_RESET;
    else if (sp_we_i)  sp_q <= f_align(sp_wdata_i);
    else if (commit_i) sp_q <= f_next(sp_q, is_pop_i);
  end

  // R4: the pointer never holds an odd byte address.
  p_sp_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q[0] == 1'b0);
endmodule

// File: rtl/spu_frame.sv
`timescale 1ns/1ps
module spu_frame #(
  parameter int DW  = 16,
  parameter int PCW = 23,
  parameter int SRW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           exc_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_i,
  output logic [DW-1:0]  lo_word_o,
  output logic [DW-1:0]  hi_word_o,
  output logic           hi_is_exc_o
);
  localparam int HIW  = PCW - DW;
  localparam int PADW = DW - HIW - SRW;

  logic [HIW-1:0] pc_hi;
  logic [DW-1:0]  call_word;
  logic [DW-1:0]  exc_word;
  logic [DW-1:0]  hi_q;
  logic           exc_q;

  assign pc_hi = pc_i[PCW-1:DW];

  // Call: everything above the upper PC bits is zero.
  function automatic logic [DW-1:0] f_call_word(input logic [HIW-1:0] hi);
    return {{(DW-HIW){1'b0}}, hi};
  endfunction

  assign call_word = f_call_word(pc_hi);

  generate
    if (PADW > 0) begin : g_padded
      assign exc_word = {sr_i, {PADW{1'b0}}, pc_hi};
    end else begin : g_packed
      assign exc_word = {sr_i, pc_hi};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      exc_q <= 1'b0;
    end else if (load_i) begin
      hi_q  <= exc_i ? exc_word : call_word;
      exc_q <= exc_i;
    end
  end

  assign lo_word_o   = pc_i[DW-1:0];
  assign hi_word_o   = hi_q;
  assign hi_is_exc_o = exc_q;
endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
module stack_ptr_unit #(
  parameter int            DW       = 16,
  parameter int            PCW      = 23,
  parameter int            SRW      = 8,
  parameter logic [DW-1:0] FLOOR    = 16'h0800,
  parameter logic [DW-1:0] SP_RESET = 16'h0800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic           sp_we_i,
  input  logic [DW-1:0]  sp_wdata_i,
  input  logic           lim_we_i,
  input  logic [DW-1:0]  lim_wdata_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [SRW-1:0] sr_i,
  output logic [DW-1:0]  mem_addr_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           trap_o,
  output logic           busy_o,
  output logic [DW-1:0]  sp_o
);
  import spu_pkg::*;

  spu_phase_e    phase_q;
  spu_req_e      req;
  logic          in_first;
  logic          ev_frame_start;
  logic          ev_second;
  logic          ev_access;
  logic          ev_pop;
  logic          ev_viol;
  logic          ev_trap;
  logic          ev_commit;
  logic          ovf, unf;
  logic [DW-1:0] lim_use;
  logic [DW-1:0] ea;
  logic [DW-1:0] frame_lo, frame_hi;
  logic          frame_exc;

  // Request priority: exception, call, push, pop.
  always_comb begin
    if (exc_i)       req = REQ_EXC;
    else if (call_i) req = REQ_CALL;
    else if (push_i) req = REQ_PUSH;
    else if (pop_i)  req = REQ_POP;
    else             req = REQ_NONE;
  end

  assign in_first       = (phase_q == PH_FIRST) && !sp_we_i;
  assign ev_frame_start = in_first && ((req == REQ_CALL) || (req == REQ_EXC));
  assign ev_second      = (phase_q == PH_SECOND) && !sp_we_i;
  assign ev_access      = ev_second || (in_first && (req != REQ_NONE));
  assign ev_pop         = in_first && (req == REQ_POP);
  assign ev_viol        = ovf || unf;
  assign ev_trap        = ev_access && ev_viol;
  assign ev_commit      = ev_access && !ev_viol;

  spu_limit #(.DW(DW)) i_limit (
    .clk         (clk),
    .rst_n       (rst_n),
    .lim_we_i    (lim_we_i),
    .lim_wdata_i (lim_wdata_i),
    .lim_use_o   (lim_use)
  );

  spu_agu #(.DW(DW), .FLOOR(FLOOR), .SP_RESET(SP_RESET)) i_agu (
    .clk        (clk),
    .rst_n      (rst_n),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .is_pop_i   (ev_pop),
    .commit_i   (ev_commit),
    .lim_i      (lim_use),
    .sp_o       (sp_o),
    .ea_o       (ea),
    .ovf_o      (ovf),
    .unf_o      (unf)
  );

  spu_frame #(.DW(DW), .PCW(PCW), .SRW(SRW)) i_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ev_frame_start),
    .exc_i       (req == REQ_EXC),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .lo_word_o   (frame_lo),
    .hi_word_o   (frame_hi),
    .hi_is_exc_o (frame_exc)
  );

  // The second word is issued only after a committed first word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase_q <= PH_FIRST;
    else if (ev_frame_start && ev_commit) phase_q <= PH_SECOND;
    else                                  phase_q <= PH_FIRST;
  end

  always_comb begin
    if (phase_q == PH_SECOND)                       mem_wdata_o = frame_hi;
    else if ((req == REQ_CALL) || (req == REQ_EXC)) mem_wdata_o = frame_lo;
    else                                            mem_wdata_o = push_data_i;
  end

  assign mem_addr_o = ea;
  assign mem_we_o   = ev_commit && !ev_pop;
  assign mem_re_o   = ev_commit && ev_pop;
  assign trap_o     = ev_trap;
  assign busy_o     = (phase_q == PH_SECOND);

  // R7: a trap suppresses the memory access.
  p_trap_blocks_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (!mem_we_o && !mem_re_o));

  // R7: a trap leaves the pointer unchanged.
  p_trap_holds_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> $stable(sp_o));

  // R2: each written word advances the pointer to one word past its address.
  p_write_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (sp_o == $past(mem_addr_o) + DW'(2)));

  // R3: a read leaves the pointer at the address that was read.
  p_read_retreats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> (sp_o == $past(mem_addr_o)));

  // R8: the busy cycle always follows a written first word.
  p_busy_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $past(mem_we_o));

  // R8: the upper word of a call frame has its top bit clear.
  p_call_msb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_we_o && !frame_exc) |-> (mem_wdata_o[DW-1] == 1'b0));
endmodule

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, exc_i = 0;
  logic [15:0] push_data_i = '0;
  logic        sp_we_i = 0;
  logic [15:0] sp_wdata_i = '0;
  logic        lim_we_i = 0;
  logic [15:0] lim_wdata_i = '0;
  logic [22:0] pc_i = '0;
  logic [7:0]  sr_i = '0;
  logic [15:0] mem_addr_o, mem_wdata_o, sp_o;
  logic        mem_we_o, mem_re_o, trap_o, busy_o;

  int n_total = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] sp_m, lim_m;

  always #10 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .exc_i(exc_i), .push_data_i(push_data_i), .sp_we_i(sp_we_i),
    .sp_wdata_i(sp_wdata_i), .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i),
    .pc_i(pc_i), .sr_i(sr_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o), .trap_o(trap_o),
    .busy_o(busy_o), .sp_o(sp_o)
  );

  function automatic bit viol(input logic [15:0] ea, input logic [15:0] lim);
    return (ea > lim) || (ea < 16'h0800);
  endfunction

  function automatic logic [15:0] hi_word(input bit ex, input logic [22:0] pc,
                                          input logic [7:0] sr);
    return ex ? {sr, 1'b0, pc[22:16]} : {9'b0, pc[22:16]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit pu, input bit po, input bit ca, input bit ex,
                       input bit sw, input logic [15:0] sd, input bit lw,
                       input logic [15:0] ld, input logic [15:0] pd);
    @(negedge clk);
    push_i = pu; pop_i = po; call_i = ca; exc_i = ex;
    sp_we_i = sw; sp_wdata_i = sd; lim_we_i = lw; lim_wdata_i = ld;
    push_data_i = pd;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 16'h0, 0, 16'h0, 16'h0);
  endtask

  task automatic after_edge(input string tag);
    @(posedge clk);
    #1;
    chk(sp_o == sp_m, tag, sp_o, sp_m);
  endtask

  task automatic set_sp(input logic [15:0] v, input string tag);
    drive(0, 0, 0, 0, 1, v, 0, 16'h0, 16'h0);
    sp_m = {v[15:1], 1'b0};
    after_edge(tag);
  endtask

  task automatic set_lim(input logic [15:0] v);
    drive(0, 0, 0, 0, 0, 16'h0, 1, v, 16'h0);
    idle();
    lim_m = {v[15:1], 1'b0};
  endtask

  task automatic do_push(input logic [15:0] pd, input string tag);
    bit t;
    drive(1, 0, 0, 0, 0, 16'h0, 0, 16'h0, pd);
    t = viol(sp_m, lim_m);
    chk(trap_o == t, tag, trap_o, t);
    chk(mem_we_o == !t, tag, mem_we_o, !t);
    if (!t) begin
      chk(mem_addr_o == sp_m, tag, mem_addr_o, sp_m);
      chk(mem_wdata_o == pd, tag, mem_wdata_o, pd);
      sp_m = sp_m + 16'd2;
    end
    after_edge(tag);
  endtask

  task automatic do_pop(input string tag);
    bit t;
    logic [15:0] ea;
    ea = sp_m - 16'd2;
    drive(0, 1, 0, 0, 0, 16'h0, 0, 16'h0, 16'h0);
    t = viol(ea, lim_m);
    chk(trap_o == t, tag, trap_o, t);
    chk(mem_re_o == !t, tag, mem_re_o, !t);
    chk(mem_we_o == 1'b0, tag, mem_we_o, 0);
    if (!t) begin
      chk(mem_addr_o == ea, tag, mem_addr_o, ea);
      sp_m = ea;
    end
    after_edge(tag);
  endtask

  task automatic do_frame(input bit ex, input logic [22:0] pc, input logic [7:0] sr,
                          input string tag);
    bit t1, t2;
    logic [15:0] hw;
    hw = hi_word(ex, pc, sr);
    pc_i = pc;
    sr_i = sr;
    drive(0, 0, !ex, ex, 0, 16'h0, 0, 16'h0, 16'h0);
    t1 = viol(sp_m, lim_m);
    chk(busy_o == 1'b0, tag, busy_o, 0);
    chk(trap_o == t1, tag, trap_o, t1);
    chk(mem_we_o == !t1, tag, mem_we_o, !t1);
    if (t1) begin
      after_edge(tag);
      return;
    end
    chk(mem_addr_o == sp_m, tag, mem_addr_o, sp_m);
    chk(mem_wdata_o == pc[15:0], tag, mem_wdata_o, pc[15:0]);
    sp_m = sp_m + 16'd2;
    // Second cycle: the PC and status inputs move and a push is requested (R12: ignored).
    drive(1, 0, 0, 0, 0, 16'h0, 0, 16'h0, 16'hDEAD);
    pc_i = ~pc;
    sr_i = ~sr;
    #1;
    t2 = viol(sp_m, lim_m);
    chk(busy_o == 1'b1, tag, busy_o, 1);
    chk(mem_addr_o == sp_m, tag, mem_addr_o, sp_m);
    chk(trap_o == t2, tag, trap_o, t2);
    chk(mem_we_o == !t2, tag, mem_we_o, !t2);
    if (!t2) begin
      chk(mem_wdata_o == hw, tag, mem_wdata_o, hw);
      sp_m = sp_m + 16'd2;
    end
    after_edge(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk(sp_o == 16'h0800, "R1 sp", sp_o, 16'h0800);
    chk(busy_o == 0 && trap_o == 0, "R1 busy/trap", {busy_o, trap_o}, 0);
    chk(mem_we_o == 0 && mem_re_o == 0, "R1 strobes", {mem_we_o, mem_re_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    sp_m = 16'h0800;
    after_edge("R1 released");

    // R5: limit sweep, pushes walking past the limit
    for (int k = 0; k < 4; k++) begin
      set_lim(16'h0A00 + 16'(2 * k));
      set_sp(16'h0A00, "R5 sp load");
      for (int j = 0; j < 5; j++) do_push(16'h5000 + 16'(j), "R5 limit");
    end

    // R2: data patterns
    set_lim(16'h0FFE);
    set_sp(16'h0C00, "R2 sp load");
    for (int i = 0; i < 8; i++) do_push(16'(i * 16'h1357) ^ 16'hA5A5, "R2 push data");

    // R3 and R6: pops down to and past the floor
    set_sp(16'h0806, "R3 sp load");
    for (int i = 0; i < 4; i++) do_pop("R3 R6 pop");
    chk(sp_m == 16'h0800, "R6 floor model", sp_m, 16'h0800);

    // R6: push from a pointer below the floor, then R7: trap is a single pulse
    set_sp(16'h0700, "R6 sp load");
    do_push(16'h1111, "R6 push below floor");
    idle();
    chk(trap_o == 1'b0, "R7 trap pulse", trap_o, 0);

    // R4: alignment of pointer and limit
    set_sp(16'h0A03, "R4 sp align");
    set_lim(16'h0A03);
    do_push(16'h2222, "R4 lim align ok");
    do_push(16'h3333, "R4 lim align trap");

    // R8 and R9: call and exception frames
    set_lim(16'h0FFE);
    set_sp(16'h0900, "R8 sp load");
    for (int i = 0; i < 8; i++) begin
      logic [22:0] pc;
      pc = {7'(i * 19 + 7'h6D), 16'(i * 16'h2F1B + 16'h00C4)};
      do_frame(1'b0, pc, 8'(i * 8'h2B), "R8 call frame");
      do_frame(1'b1, pc, 8'(i * 8'h2B + 8'h81), "R9 exc frame");
    end

    // R10: second word traps, then first word traps
    set_lim(16'h0B00);
    set_sp(16'h0B00, "R10 sp load");
    do_frame(1'b0, 23'h7F_1234, 8'h00, "R10 second word trap");
    do_frame(1'b1, 23'h7F_5678, 8'hA5, "R10 first word trap");
    idle();
    chk(busy_o == 1'b0, "R10 no busy after first trap", busy_o, 0);
    chk(trap_o == 1'b0, "R7 pulse after frame", trap_o, 0);

    // R11: limit write hazard
    set_lim(16'h0FFE);
    set_sp(16'h0900, "R11 sp load");
    drive(0, 0, 0, 0, 0, 16'h0, 1, 16'h08FE, 16'h0);
    do_push(16'h4444, "R11 old limit used");
    lim_m = 16'h08FE;
    do_push(16'h5555, "R11 new limit used");

    // R12: priorities
    set_lim(16'h0FFE);
    set_sp(16'h0C00, "R12 sp load");
    drive(1, 0, 0, 0, 1, 16'h0C10, 0, 16'h0, 16'h7777);
    chk(mem_we_o == 1'b0 && trap_o == 1'b0, "R12 sp write wins", {mem_we_o, trap_o}, 0);
    sp_m = 16'h0C10;
    after_edge("R12 sp write wins");
    drive(1, 1, 0, 0, 0, 16'h0, 0, 16'h0, 16'h1234);
    chk(mem_we_o == 1'b1 && mem_re_o == 1'b0, "R12 push over pop", {mem_we_o, mem_re_o}, 2'b10);
    chk(mem_addr_o == sp_m, "R12 push over pop addr", mem_addr_o, sp_m);
    chk(mem_wdata_o == 16'h1234, "R12 push over pop data", mem_wdata_o, 16'h1234);
    sp_m = sp_m + 16'd2;
    after_edge("R12 push over pop");
    pc_i = 23'h3C_ABCD;
    sr_i = 8'h5A;
    drive(1, 0, 1, 1, 0, 16'h0, 0, 16'h0, 16'h9999);
    chk(mem_wdata_o == 16'hABCD, "R12 frame over push", mem_wdata_o, 16'hABCD);
    sp_m = sp_m + 16'd2;
    idle();
    chk(mem_wdata_o == hi_word(1'b1, 23'h3C_ABCD, 8'h5A), "R12 exc over call",
        mem_wdata_o, hi_word(1'b1, 23'h3C_ABCD, 8'h5A));
    sp_m = sp_m + 16'd2;
    after_edge("R12 frame sp");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule